// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the digital control of a 16 Kbit serial memory that sits on a two-wire bus as a slave. It samples the bus clock and data lines on a fast system clock, finds start and stop conditions, and decodes an address byte whose three middle bits pick one of eight internal 256-byte blocks. A word address byte sets the low eight bits of an 11-bit address counter. The master can then write one byte or up to sixteen bytes of one page, or read from the current address, from a freshly set address, or sequentially across the whole array.

Written bytes are gathered in a page buffer and committed together when the stop arrives. A self-timed write cycle of a parameter number of system clocks follows, during which the controller ignores its own address. A write-protect input locks the upper half of the array. The data line is open drain, so the block only produces a pull-down enable. The array itself is a register array that resets to the erased value.

Top module: `eep_slave_ctrl`

## Requirements
- R1: After reset the pull-down enable is 0 and every byte of the array reads as 0xFF.
- R2: Bits are taken MSB first on the rising clock edge; a data fall with clock high is a start, a data rise with clock high is a stop, and bytes clocked in before any start are never acknowledged.
- R3: The address byte is 1010 in bits 7:4, block select in bits 3:1 and direction in bit 0 (1 = read); the block acknowledges it by pulling data low through the ninth clock, and any other value in bits 7:4 gets no acknowledge and no further response until the next start.
- R4: The byte after a write address byte sets address bits 7:0; each data byte that follows is acknowledged and lands at the counter address once a stop ends the transfer.
- R5: In a write, only address bits 3:0 advance after each data byte, so bytes past the end of a 16-byte page overwrite the start of that same page.
- R6: A stop that ends a write holding at least one data byte starts a write cycle of WR_CYCLES system clocks; during it the address byte is not acknowledged, after it the address byte is acknowledged.
- R7: A repeated start after the word address starts a read at that address; data bytes of a write that ends in a repeated start instead of a stop are discarded and start no write cycle.
- R8: A read address byte alone reads from the address formed by its block bits and counter bits 7:0; the counter advances by one after each byte sent.
- R9: While the master acknowledges, reading continues with the next address, wrapping from 0x7FF to 0x000; a master not-acknowledge ends the read with data released.
- R10: With write protect high, a write to address bit 10 = 1 gets both address bytes acknowledged, its data bytes not acknowledged, leaves the array unchanged and starts no write cycle; lower-half writes and all reads work as usual.
- R11: The pull-down enable only changes after a clock falling edge or a start or stop, never while the clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_oe_o | output | 1 | Pull the data line low when 1 |

## Verification
A wrong bit counter or state shows within one byte as a missing or misplaced acknowledge, which the bench reads on the ninth clock of every byte it sends. A corrupted address counter or page buffer stays hidden until a read, so every write is followed by a read-back of the whole affected page or of one byte in each of the eight blocks, and page wrap and 0x7FF wrap get their own reads. A write cycle that starts when it should not, or lasts the wrong time, shows in the number of unacknowledged polls right after the stop.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} eep_state_e;
  typedef enum logic [1:0] {PH_DEV, PH_WORD, PH_DATA} eep_phase_e;
endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [0],[1] synchronise, [2] holds the previous sample
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_o     = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     we_i,
  input  logic [PAGE_W-1:0]        idx_i,
  input  logic [7:0]               wdata_i,
  input  logic [ADDR_W-1:PAGE_W]   base_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [7:0]               rdata_o,
  output logic                     pending_o
);
  localparam int unsigned LANES = 1 << PAGE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0]             mem [DEPTH];
  logic [7:0]             pbuf_q [LANES];
  logic [LANES-1:0]       mask_q;
  logic [ADDR_W-1:PAGE_W] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
      for (int l = 0; l < int'(LANES); l++) pbuf_q[l] <= '0;
    end else if (clr_i || commit_i) begin
      mask_q <= '0;
    end else if (we_i) begin
      pbuf_q[idx_i] <= wdata_i;
      mask_q[idx_i] <= 1'b1;
      base_q        <= base_i;
    end
  end

  // whole page lands in one clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int l = 0; l < int'(LANES); l++)
        if (mask_q[l]) mem[{base_q, PAGE_W'(l)}] <= pbuf_q[l];
    end
  end

  assign rdata_o   = mem[raddr_i];
  assign pending_o = |mask_q;
endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned WR_CYCLES = 1000,
  parameter logic [3:0]  DEV_ID    = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int unsigned BLK_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det, busy;
  logic commit, pending, buf_we, dev_hit, wp_block, byte_end;
  logic [7:0] rdata;

  eep_state_e        state_q;
  eep_phase_e        phase_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, mack_q, oe_q;

  eep_line_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eep_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i(start_det), .we_i(buf_we), .idx_i(addr_q[PAGE_W-1:0]),
    .wdata_i(sh_q), .base_i(addr_q[ADDR_W-1:PAGE_W]),
    .commit_i(commit), .raddr_i(addr_q), .rdata_o(rdata), .pending_o(pending)
  );

  assign dev_hit  = (sh_q[7:4] == DEV_ID) && !busy;
  assign wp_block = wp_i && addr_q[ADDR_W-1];
  assign byte_end = (state_q == ST_RX) && scl_fall && (cnt_q == 4'd8);
  assign buf_we   = byte_end && (phase_q == PH_DATA) && !wp_block;
  assign commit   = stop_det && pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_RX;
      phase_q <= PH_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end) begin
            cnt_q <= '0;
            unique case (phase_q)
              PH_DEV: begin
                if (dev_hit) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                  rw_q    <= sh_q[0];
                  addr_q[ADDR_W-1 -: BLK_W] <= sh_q[BLK_W:1];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              PH_WORD: begin
                oe_q        <= 1'b1;
                state_q     <= ST_ACK;
                addr_q[7:0] <= sh_q;
              end
              PH_DATA: begin
                if (!wp_block) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                  addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (phase_q == PH_DEV && rw_q) begin
              state_q <= ST_TX;
              sh_q    <= {rdata[6:0], 1'b0};
              oe_q    <= ~rdata[7];
              cnt_q   <= '0;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
              phase_q <= (phase_q == PH_DEV) ? PH_WORD : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
              addr_q  <= addr_q + 1'b1;
            end else begin
              oe_q  <= ~sh_q[7];
              sh_q  <= {sh_q[6:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_TX;
              sh_q    <= {rdata[6:0], 1'b0};
              oe_q    <= ~rdata[7];
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_fall_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       oe_i,
  input logic       busy_i,
  input logic       buf_we_i,
  input logic       wp_i,
  input logic       addr_hi_i,
  input eep_state_e state_i,
  input eep_phase_e phase_i
);
  // R11
  oe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_i) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));

  // R6
  cycle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  // R6
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && state_i == ST_ACK) |-> (phase_i != PH_DEV));

  // R10
  wp_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> !(wp_i && addr_hi_i));

  // R9
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !oe_i);
endmodule

bind eep_slave_ctrl eep_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall), .start_i(start_det),
  .stop_i(stop_det), .oe_i(sda_oe_o), .busy_i(busy), .buf_we_i(buf_we),
  .wp_i(wp_i), .addr_hi_i(addr_q[ADDR_W-1]), .state_i(state_q), .phase_i(phase_q)
);

// File: tb/eep_slave_ctrl_test.sv
module eep_slave_ctrl_test;
  localparam int WR = 400;
  localparam int Q  = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   checks = 0, errors = 0;
  logic [7:0] exp_mem [2048];

  assign sda_line = msda & ~sda_oe;
  always #5 clk = ~clk;

  eep_slave_ctrl #(.WR_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; waitq(1); scl = 1'b1; waitq(1);
    msda = 1'b0; waitq(1); scl = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    msda = 1'b0; waitq(1); scl = 1'b1; waitq(1); msda = 1'b1; waitq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; waitq(1); scl = 1'b1; waitq(2); scl = 1'b0; waitq(1);
    end
    msda = 1'b1; waitq(1); scl = 1'b1; waitq(1);
    ack = !sda_line; a0 = sda_oe;
    waitq(1); a1 = sda_oe;
    chk(a0 == a1, "R11 enable stable while clock high", int'(a1), int'(a0));
    scl = 1'b0; waitq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      waitq(1); scl = 1'b1; waitq(1); d[i] = sda_line; waitq(1); scl = 1'b0; waitq(1);
    end
    msda = !give_ack; waitq(1); scl = 1'b1; waitq(2); scl = 1'b0; waitq(1);
    msda = 1'b1;
  endtask

  task automatic poll_ready(output int tries);
    bit ack;
    tries = 0;
    for (int i = 0; i < 50; i++) begin
      bus_start(); send_byte(8'hA0, ack); bus_stop();
      if (ack) break;
      tries++;
    end
  endtask

  task automatic write_seq(input logic [10:0] a, input int n, input logic [7:0] seed, input string tag);
    bit ack;
    int tries;
    bus_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack); chk(ack, {tag, " addr ack"}, int'(ack), 1);
    send_byte(a[7:0], ack);                chk(ack, {tag, " word ack"}, int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 13);
      send_byte(d, ack); chk(ack, {tag, " data ack"}, int'(ack), 1);
      exp_mem[{a[10:4], 4'(a[3:0] + 4'(k))}] = d;
    end
    bus_stop();
    poll_ready(tries);
    chk(tries > 0 && tries < 50, "R6 write cycle refuses then accepts address", tries, 1);
  endtask

  task automatic read_seq(input logic [10:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack); chk(ack, {tag, " addr ack"}, int'(ack), 1);
    send_byte(a[7:0], ack);                chk(ack, {tag, " word ack"}, int'(ack), 1);
    bus_start();
    send_byte({4'hA, a[10:8], 1'b1}, ack); chk(ack, "R7 read address ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      logic [10:0] ea;
      ea = a + 11'(k);
      recv_byte(k != n - 1, d);
      chk(d == exp_mem[ea], tag, int'(d), int'(exp_mem[ea]));
    end
    chk(sda_oe == 1'b0, "R9 released after not-acknowledge", int'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    int tries;
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    waitq(2);
    chk(sda_oe == 1'b0, "R1 enable low after reset", int'(sda_oe), 0);
    read_seq(11'h3C5, 1, "R1 erased value");

    // R2 bytes without a start are ignored
    send_byte(8'hA0, ack);
    chk(!ack, "R2 no response before start", int'(ack), 0);

    // R3 foreign id: no ack, next byte ignored too
    bus_start();
    send_byte(8'hB0, ack); chk(!ack, "R3 foreign id not acknowledged", int'(ack), 0);
    send_byte(8'hA0, ack); chk(!ack, "R3 silent until next start", int'(ack), 0);
    bus_stop();

    // R3 R4 one byte in each block
    for (int b = 0; b < 8; b++)
      write_seq(11'(b * 256 + b * 17), 1, 8'(b * 29 + 1), "R4 byte write");
    for (int b = 0; b < 8; b++)
      read_seq(11'(b * 256 + b * 17), 1, "R3 block select read-back");

    // R5 page wrap, 20 bytes from offset 5
    write_seq(11'h535, 20, 8'h07, "R5 page write");
    read_seq(11'h530, 16, "R5 page contents after wrap");

    // full page, then current address read across the page edge
    write_seq(11'h240, 16, 8'h41, "R5 full page");
    write_seq(11'h230, 16, 8'h90, "R5 full page");
    read_seq(11'h23E, 1, "R9 single read");
    bus_start();
    send_byte({4'hA, 3'd2, 1'b1}, ack); chk(ack, "R8 current read ack", int'(ack), 1);
    recv_byte(1'b1, d); chk(d == exp_mem[11'h23F], "R8 current address", int'(d), int'(exp_mem[11'h23F]));
    recv_byte(1'b0, d); chk(d == exp_mem[11'h240], "R8 counter advance", int'(d), int'(exp_mem[11'h240]));
    bus_stop();

    // R9 wrap from top of array
    write_seq(11'h7F8, 8, 8'hC3, "R9 top page write");
    read_seq(11'h7FC, 6, "R9 sequential wrap");

    // R10 write protect
    wp = 1'b1;
    bus_start();
    send_byte({4'hA, 3'd6, 1'b0}, ack); chk(ack, "R10 addr ack under protect", int'(ack), 1);
    send_byte(8'hA0, ack);              chk(ack, "R10 word ack under protect", int'(ack), 1);
    send_byte(8'h77, ack);              chk(!ack, "R10 data refused", int'(ack), 0);
    send_byte(8'h78, ack);              chk(!ack, "R10 later data refused", int'(ack), 0);
    bus_stop();
    poll_ready(tries);
    chk(tries == 0, "R10 no write cycle", tries, 0);
    read_seq(11'h6A0, 2, "R10 protected bytes unchanged");
    read_seq(11'h533, 4, "R10 read of upper half allowed");
    write_seq(11'h1A0, 3, 8'h5C, "R10 lower half writable");
    read_seq(11'h1A0, 3, "R10 lower half read-back");
    wp = 1'b0;
    write_seq(11'h6A0, 2, 8'h21, "R10 upper half writable when low");
    read_seq(11'h6A0, 2, "R10 upper half read-back");

    // R7 data followed by repeated start is dropped
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R7 addr ack", int'(ack), 1);
    send_byte(8'hC0, ack); chk(ack, "R7 word ack", int'(ack), 1);
    send_byte(8'h33, ack); chk(ack, "R7 data ack", int'(ack), 1);
    bus_start();
    send_byte(8'hA1, ack); chk(ack, "R7 read after repeated start", int'(ack), 1);
    recv_byte(1'b0, d); chk(d == exp_mem[11'h0C1], "R7 read at next address", int'(d), int'(exp_mem[11'h0C1]));
    bus_stop();
    poll_ready(tries);
    chk(tries == 0, "R7 no write cycle after repeated start", tries, 0);
    read_seq(11'h0C0, 1, "R7 discarded byte not stored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule